// File: doc/BRIEF.md
# Prioritised Interrupt Request Controller

This block keeps three sets of interrupt vectors, one bit per vector: vectors waiting for service (pending set), vectors the CPU is currently handling (service set), and vectors that arrived level-triggered (level set). An interrupt source presents a vector and a trigger type on the request port. The block compares the best pending vector against a processor priority. That priority is formed from a software-written task priority and the most important vector in service. When the pending vector wins, the block presents it to the CPU.

When the CPU acknowledges, the vector moves from the pending set to the service set, which raises the processor priority. An end-of-interrupt write retires the most important vector in service. If that vector was level-triggered, the block pulses a notification carrying the vector number so that the originating source can re-sample its line. Decoding of a register bus and routing between several controllers are left to the surrounding logic.

Top module: `vec_irq_ctrl`

## Requirements
- R1: After reset the pending, service and level sets and the task priority are all zero. ppr reads 0 and intr_valid is low.
- R2: ppr equals the 8-bit task priority when its upper nibble is at least the upper nibble of the highest vector in service. Otherwise ppr equals that vector with bits 3:0 cleared. An empty service set counts as vector 0. A task priority write takes effect in the next cycle.
- R3: intr_valid is high exactly when the block is enabled, the pending set is non-empty, and the highest pending vector ANDed with 0xF0 is strictly greater than ppr. intr_vector then carries that vector.
- R4: intr_ack while intr_valid is high clears the presented vector from the pending set and sets it in the service set at that clock edge. ppr is recomputed from the new service set.
- R5: An eoi_we strobe clears the highest set bit of the service set. With an empty service set the strobe changes nothing.
- R6: If the retired vector's level bit is set, that bit is cleared. level_eoi_valid is then high for exactly the next cycle, with level_eoi_vector equal to the retired vector. A retired edge vector gives no pulse.
- R7: req_accept is high in the cycle of a request when the block is enabled and the vector's pending bit is clear. On such a request the pending bit is set, and the level bit is set for req_level=1 (level) and cleared for req_level=0 (edge).
- R8: A request for a vector whose pending bit is already set is not accepted. A level request then leaves the level bit unchanged, while an edge request clears it.
- R9: With en_hw or en_sw low, requests are dropped with req_accept low, and intr_valid is low.
- R10: intr_ack while intr_valid is low changes no state.
- R11: Within one clock edge, end-of-interrupt is applied first, then acknowledge, then the request. The request's pending test uses the pending set from before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_hw | input | 1 | Hardware enable |
| en_sw | input | 1 | Software enable |
| req_valid | input | 1 | Request strobe |
| req_vector | input | 8 | Requested vector |
| req_level | input | 1 | 1 = level trigger, 0 = edge trigger |
| req_accept | output | 1 | Request newly accepted (combinational) |
| tpr_we | input | 1 | Task priority write strobe |
| tpr_wdata | input | 8 | Task priority value |
| eoi_we | input | 1 | End-of-interrupt strobe |
| intr_valid | output | 1 | An interrupt is presented to the CPU |
| intr_vector | output | 8 | Presented vector |
| intr_ack | input | 1 | CPU acknowledge |
| ppr | output | 8 | Current processor priority |
| level_eoi_valid | output | 1 | One-cycle level end-of-interrupt pulse |
| level_eoi_vector | output | 8 | Vector retired by that pulse |

## Verification
A corrupted service set appears on ppr in the same cycle, because ppr is combinational from the stored state. It also appears on level_eoi_vector at the next end-of-interrupt. A wrong pending bit shows on intr_vector as soon as that vector becomes the best candidate, and it shows on req_accept at the next request for the same vector. A wrong level bit stays hidden until its vector is retired, and then shows as a missing or extra pulse one cycle after the strobe. The bench therefore drives many acknowledge and retire cycles on a small pool of colliding vectors, so that such faults surface within a few dozen cycles.

// File: rtl/irc_pkg.sv
package irc_pkg;
    parameter int NUM_VEC = 256;
    parameter int VEC_W   = $clog2(NUM_VEC);
    parameter int CLS_W   = 4;
    localparam int SUB_W  = VEC_W - CLS_W;

    typedef logic [VEC_W-1:0] vec_t;

    typedef struct packed {
        logic [NUM_VEC-1:0] pend;
        logic [NUM_VEC-1:0] serv;
        logic [NUM_VEC-1:0] lvl;
        vec_t               task_pri;
        logic               leoi_v;
        vec_t               leoi_vec;
    } irc_state_t;

    function automatic vec_t class_of(input vec_t v);
        return {v[VEC_W-1 -: CLS_W], {SUB_W{1'b0}}};
    endfunction
endpackage

// File: rtl/irc_prio_enc.sv
module irc_prio_enc #(
    parameter int WIDTH = 256,
    parameter int GRP   = 16,
    localparam int IDX_W = $clog2(WIDTH),
    localparam int NGRP  = WIDTH / GRP,
    localparam int GW    = $clog2(GRP),
    localparam int NW    = $clog2(NGRP)
) (
    input  logic [WIDTH-1:0] bits_i,
    output logic             found_o,
    output logic [IDX_W-1:0] idx_o
);
    logic [NGRP-1:0] grp_hit;
    logic [GW-1:0]   grp_idx [NGRP];

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        always_comb begin
            grp_hit[g] = 1'b0;
            grp_idx[g] = '0;
            for (int b = 0; b < GRP; b++) begin
                if (bits_i[g*GRP + b]) begin
                    grp_hit[g] = 1'b1;
                    grp_idx[g] = GW'(b);
                end
            end
        end
    end

    logic [NW-1:0] sel;
    always_comb begin
        sel = '0;
        for (int g = 0; g < NGRP; g++) begin
            if (grp_hit[g]) sel = NW'(g);
        end
        found_o = |grp_hit;
        idx_o   = {sel, grp_idx[sel]};
    end
endmodule

// File: rtl/irc_ppr_calc.sv
module irc_ppr_calc
    import irc_pkg::*;
(
    input  vec_t task_pri_i,
    input  logic serv_found_i,
    input  vec_t serv_idx_i,
    output vec_t ppr_o
);
    vec_t serv_eff;
    always_comb begin
        serv_eff = serv_found_i ? serv_idx_i : '0;
        if (task_pri_i[VEC_W-1 -: CLS_W] >= serv_eff[VEC_W-1 -: CLS_W])
            ppr_o = task_pri_i;
        else
            ppr_o = class_of(serv_eff);
    end
endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl
    import irc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_hw,
    input  logic             en_sw,
    input  logic             req_valid,
    input  logic [VEC_W-1:0] req_vector,
    input  logic             req_level,
    output logic             req_accept,
    input  logic             tpr_we,
    input  logic [VEC_W-1:0] tpr_wdata,
    input  logic             eoi_we,
    output logic             intr_valid,
    output logic [VEC_W-1:0] intr_vector,
    input  logic             intr_ack,
    output logic [VEC_W-1:0] ppr,
    output logic             level_eoi_valid,
    output logic [VEC_W-1:0] level_eoi_vector
);
    irc_state_t state_q, state_d;

    logic pend_found, serv_found;
    vec_t pend_idx, serv_idx;

    irc_prio_enc #(.WIDTH(NUM_VEC)) u_pend_enc (
        .bits_i (state_q.pend),
        .found_o(pend_found),
        .idx_o  (pend_idx)
    );

    irc_prio_enc #(.WIDTH(NUM_VEC)) u_serv_enc (
        .bits_i (state_q.serv),
        .found_o(serv_found),
        .idx_o  (serv_idx)
    );

    irc_ppr_calc u_ppr (
        .task_pri_i  (state_q.task_pri),
        .serv_found_i(serv_found),
        .serv_idx_i  (serv_idx),
        .ppr_o       (ppr)
    );

    logic enabled, offer, take, retire;

    always_comb begin
        enabled    = en_hw & en_sw;
        offer      = enabled & pend_found & (class_of(pend_idx) > ppr);
        take       = offer & intr_ack;
        retire     = eoi_we & serv_found;
        req_accept = req_valid & enabled & ~state_q.pend[req_vector];

        state_d        = state_q;
        state_d.leoi_v = 1'b0;

        if (tpr_we) state_d.task_pri = tpr_wdata;

        if (retire) begin
            state_d.serv[serv_idx] = 1'b0;
            if (state_q.lvl[serv_idx]) begin
                state_d.lvl[serv_idx] = 1'b0;
                state_d.leoi_v        = 1'b1;
                state_d.leoi_vec      = serv_idx;
            end
        end

        if (take) begin
            state_d.serv[pend_idx] = 1'b1;
            state_d.pend[pend_idx] = 1'b0;
        end

        if (req_valid && enabled) begin
            if (!state_q.pend[req_vector]) begin
                state_d.pend[req_vector] = 1'b1;
                state_d.lvl[req_vector]  = req_level;
            end else if (!req_level) begin
                state_d.lvl[req_vector]  = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign intr_valid       = offer;
    assign intr_vector      = pend_idx;
    assign level_eoi_valid  = state_q.leoi_v;
    assign level_eoi_vector = state_q.leoi_vec;
endmodule

// File: rtl/irc_chk.sv
module irc_chk
    import irc_pkg::*;
(
    input logic clk,
    input logic rst_n,
    input logic en_hw,
    input logic en_sw,
    input logic req_valid,
    input logic req_accept,
    input logic eoi_we,
    input logic intr_valid,
    input vec_t intr_vector,
    input logic intr_ack,
    input vec_t ppr,
    input vec_t task_pri,
    input logic level_eoi_valid
);
    // R3
    offer_above_ppr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        intr_valid |-> (class_of(intr_vector) > ppr));

    // R2
    ppr_not_below_tpr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ppr >= task_pri);

    // R4
    ack_raises_ppr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (intr_valid && intr_ack) |=> (class_of(ppr) >= class_of($past(intr_vector))));

    // R6
    leoi_after_eoi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        level_eoi_valid |-> $past(eoi_we));

    // R9
    disabled_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(en_hw && en_sw) |-> (!req_accept && !intr_valid));

    // R7
    accept_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_accept |-> req_valid);
endmodule

bind vec_irq_ctrl irc_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .en_hw          (en_hw),
    .en_sw          (en_sw),
    .req_valid      (req_valid),
    .req_accept     (req_accept),
    .eoi_we         (eoi_we),
    .intr_valid     (intr_valid),
    .intr_vector    (intr_vector),
    .intr_ack       (intr_ack),
    .ppr            (ppr),
    .task_pri       (state_q.task_pri),
    .level_eoi_valid(level_eoi_valid)
);

// File: tb/tb_vec_irq_ctrl.sv
module tb_vec_irq_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en_hw = 1'b1, en_sw = 1'b1;
    logic       req_valid = 1'b0, req_level = 1'b0;
    logic [7:0] req_vector = '0;
    logic       req_accept;
    logic       tpr_we = 1'b0;
    logic [7:0] tpr_wdata = '0;
    logic       eoi_we = 1'b0;
    logic       intr_valid, intr_ack = 1'b0;
    logic [7:0] intr_vector, ppr;
    logic       level_eoi_valid;
    logic [7:0] level_eoi_vector;

    always #2 clk = ~clk;

    vec_irq_ctrl dut (.*);

    int checks = 0, failures = 0;
    bit done = 0;
    string phase = "R3";

    logic [255:0] m_pend = '0, m_serv = '0, m_lvl = '0;
    int  m_tpr = 0;
    bit  m_leoi_v = 0;
    int  m_leoi_vec = 0;

    function automatic int top_bit(input logic [255:0] v);
        for (int i = 255; i >= 0; i--) if (v[i]) return i;
        return -1;
    endfunction

    task automatic chk(input int act, input int exp, input string tag);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic step(input bit rv, input int vec, input bit lv, input bit ak,
                        input bit eo, input bit tw, input int tv,
                        input bit eh, input bit es);
        int ph, sh, sv, eppr, acc_tag_sel;
        bit en, off, eacc;
        logic [255:0] pend0;
        @(negedge clk);
        req_valid = rv; req_vector = vec[7:0]; req_level = lv; intr_ack = ak;
        eoi_we = eo; tpr_we = tw; tpr_wdata = tv[7:0]; en_hw = eh; en_sw = es;
        #1;
        en   = eh & es;
        ph   = top_bit(m_pend);
        sh   = top_bit(m_serv);
        sv   = (sh < 0) ? 0 : sh;
        eppr = ((m_tpr >> 4) >= (sv >> 4)) ? m_tpr : (sv & 'hF0);
        off  = en && (ph >= 0) && ((ph & 'hF0) > eppr);
        eacc = rv && en && !m_pend[vec];
        chk(ppr, eppr, (phase == "R3") ? "R2" : phase);
        chk(intr_valid, off, phase);
        if (off) chk(intr_vector, ph, phase);
        chk(req_accept, eacc, !en ? "R9" : (rv && m_pend[vec]) ? "R8" : "R7");
        chk(level_eoi_valid, m_leoi_v, "R6");
        if (m_leoi_v) chk(level_eoi_vector, m_leoi_vec, "R6");
        // reference update, order per R11
        pend0 = m_pend;
        m_leoi_v = 0;
        if (tw) m_tpr = tv & 'hFF;
        if (eo && sh >= 0) begin
            m_serv[sh] = 1'b0;
            if (m_lvl[sh]) begin
                m_lvl[sh] = 1'b0; m_leoi_v = 1; m_leoi_vec = sh;
            end
        end
        if (ak && off) begin
            m_serv[ph] = 1'b1; m_pend[ph] = 1'b0;
        end
        if (rv && en) begin
            if (!pend0[vec]) begin
                m_pend[vec] = 1'b1; m_lvl[vec] = lv;
            end else if (!lv) m_lvl[vec] = 1'b0;
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0,0,0,0,0,0,0,1,1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        phase = "R1"; idle(2);
        // R7 acceptance, edge and level
        phase = "R7";
        step(1,'h40,0,0,0,0,0,1,1);
        step(1,'h41,1,0,0,0,0,1,1);
        // R3 strict class comparison
        phase = "R3";
        step(0,0,0,0,0,1,'h45,1,1);
        step(0,0,0,0,0,1,'h3F,1,1);
        // R4 acknowledge moves vector, ppr rises
        phase = "R4";
        step(0,0,0,1,0,0,0,1,1);
        idle(1);
        // R5/R6 retire level vector, then edge vector, then empty
        phase = "R5";
        step(0,0,0,0,1,0,0,1,1);
        step(0,0,0,1,0,0,0,1,1);
        step(0,0,0,0,1,0,0,1,1);
        step(0,0,0,0,1,0,0,1,1);
        idle(1);
        // R8 repeated requests
        phase = "R8";
        step(1,'h80,1,0,0,0,0,1,1);
        step(1,'h80,1,0,0,0,0,1,1);
        step(0,0,0,1,0,0,0,1,1);
        step(0,0,0,0,1,0,0,1,1);
        step(1,'h90,1,0,0,0,0,1,1);
        step(1,'h90,0,0,0,0,0,1,1);
        step(0,0,0,1,0,0,0,1,1);
        step(0,0,0,0,1,0,0,1,1);
        idle(1);
        // R9 disabled
        phase = "R9";
        step(1,'h70,0,0,0,0,0,1,0);
        step(1,'h71,0,0,0,0,0,0,1);
        step(0,0,0,1,0,0,0,1,1);
        // R10 ack without offer
        phase = "R10";
        step(0,0,0,0,0,1,'hF0,1,1);
        step(1,'h60,1,0,0,0,0,1,1);
        step(0,0,0,1,0,0,0,1,1);
        step(0,0,0,1,0,1,'h00,1,1);
        // R11 same-edge ordering
        phase = "R11";
        step(1,'h60,0,1,0,0,0,1,1);
        step(1,'hA0,1,0,0,0,0,1,1);
        step(1,'hA0,1,1,1,0,0,1,1);
        step(0,0,0,0,1,0,0,1,1);
        step(0,0,0,0,1,0,0,1,1);
        idle(2);
        // mixed traffic on a small colliding pool
        phase = "R3";
        for (int i = 0; i < 4000; i++) begin
            int v;
            v = ($urandom_range(0,3) == 0) ? $urandom_range(0,255)
                                           : 16 * $urandom_range(1,15) + $urandom_range(0,2);
            step($urandom_range(0,2) == 0, v, $urandom_range(0,1),
                 $urandom_range(0,2) == 0, $urandom_range(0,4) == 0,
                 $urandom_range(0,15) == 0, $urandom_range(0,255) & 'h7F,
                 $urandom_range(0,31) != 0, $urandom_range(0,31) != 0);
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule